// File: doc/BRIEF.md
# Safe-Load Dispatch Filter

This block sits at the dispatch stage of an out-of-order core. It sits in front of a 48-entry load queue and a 48-entry store queue. For every load presented at dispatch it decides between two paths. A load may be safe and skip both the load queue and address disambiguation. Otherwise it must take a load-queue slot and follow the normal checked path.

Software marks loads in two ways. The first is a small file of one-bit condition registers. A condition-set operation writes them, and an indirect jump clears them all at once. A safe-load operation names one of these registers. The second is a scope marker. It opens a region in which every dispatched store is tagged safe in the store queue. When every valid store-queue entry carries that tag, every load is safe, including when the store queue is empty.

The block reports each dispatched load with a one-cycle strobe. The strobe carries the decision and the load-queue index it was given. The block also stalls dispatch when a queue it needs is full.

Top module: `safe_load_filter`

## Requirements
- R1: After reset, condition registers 0 to 6 read 0, both queues are empty, no classification strobe is raised and neither stall is asserted.
- R2: A condition-set operation writes its one-bit value into the register at its index. A safe-load operation naming a register that holds 1 is classified safe and takes no load-queue slot. If the register holds 0, the load is unsafe and takes a slot, unless R7 applies.
- R3: Register index 7 always reads 1 and writes to it have no effect, so a safe-load naming index 7 is always classified safe.
- R4: A safe-load that reads the same index a same-cycle condition-set writes sees the value being written.
- R5: An indirect jump clears registers 0 to 6, beginning with loads in the same cycle. A condition-set in the same cycle as the jump is discarded.
- R6: After a scope marker, including a store in the marker's own cycle, every dispatched store is tagged safe until the next flush. Stores dispatched outside a region are untagged.
- R7: Any load, plain or safe-load, is classified safe when every valid store-queue entry is tagged safe, and when the store queue is empty. A store dispatched in the same cycle as the load is not counted. Retiring the oldest store removes it from this check.
- R8: With 48 loads held in the load queue, an unsafe load asserts the load stall in the same cycle and is not dispatched. A safe load is not stalled. A load-queue release frees one slot.
- R9: Each dispatched load raises the classification strobe for exactly one cycle, one cycle after dispatch. The strobe carries safe=1 with index 0, or safe=0 with the slot index. Slots are handed out in order 0, 1, ..., 47 and then wrap to 0.
- R10: A flush empties both queues, clears all store tags, resets slot numbering to 0 and ends the scope region. A load or store in the flush cycle is discarded.
- R11: With 48 stores held, a dispatched store asserts the store stall in the same cycle and is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A load is presented at dispatch |
| ld_safe_op | input | 1 | The load is a safe-load operation |
| ld_cr_idx | input | 3 | Condition register named by the safe-load |
| st_valid | input | 1 | A store is presented at dispatch |
| scope_mark | input | 1 | Scope marker operation |
| cset_valid | input | 1 | Condition-set operation |
| cset_idx | input | 3 | Register written by the condition-set |
| cset_value | input | 1 | Value written by the condition-set |
| ijump | input | 1 | Indirect jump dispatched |
| sq_retire | input | 1 | Oldest store leaves the store queue |
| lq_release | input | 1 | Oldest load leaves the load queue |
| flush | input | 1 | Pipeline flush |
| ld_stall | output | 1 | Load held back (load queue full, load unsafe) |
| st_stall | output | 1 | Store held back (store queue full) |
| cls_valid | output | 1 | Classification strobe |
| cls_safe | output | 1 | Load was classified safe |
| cls_lq_idx | output | 6 | Load-queue slot given to an unsafe load |

## Verification
The two stalls are combinational, so the bench reads them a short delay after it drives the inputs and before the clock edge. The classification strobe is registered once. The bench therefore pushes the expected decision and slot when it drives the load, and the monitor pops it at the falling edge after the next rising edge. Condition-register writes reach a load in the same cycle through the bypass. Flush, retire and release effects reach the loads and stores of the following cycle, and the bench's model applies them at that same edge.

// File: rtl/slf_pkg.sv
package slf_pkg;
    parameter int unsigned NUM_CR      = 8;
    parameter int unsigned CR_TRUE_IDX = NUM_CR - 1;
    parameter int unsigned LQ_DEPTH    = 48;
    parameter int unsigned SQ_DEPTH    = 48;

    localparam int unsigned CR_W     = $clog2(NUM_CR);
    localparam int unsigned LQ_IDX_W = $clog2(LQ_DEPTH);
    localparam int unsigned LQ_CNT_W = $clog2(LQ_DEPTH + 1);
    localparam int unsigned SQ_IDX_W = $clog2(SQ_DEPTH);
    localparam int unsigned SQ_CNT_W = $clog2(SQ_DEPTH + 1);

    typedef struct packed {
        logic            valid;
        logic [CR_W-1:0] idx;
        logic            value;
    } cr_write_t;

    typedef struct packed {
        logic                valid;
        logic                safe;
        logic [LQ_IDX_W-1:0] lq_idx;
    } load_cls_t;
endpackage

// File: rtl/slf_cond_regs.sv
module slf_cond_regs #(
    parameter int unsigned NUM      = 8,
    parameter int unsigned TRUE_IDX = NUM - 1,
    parameter int unsigned IW       = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_value,
    input  logic          flash_clr,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_bit
);
    // Storage for the writable registers; the hardwired one never gets a flop value.
    logic [NUM-1:0] cr_rw;
    logic           wr_ok;

    assign wr_ok = wr_valid && (wr_idx != IW'(TRUE_IDX));

    always_ff @(posedge clk) begin
        if (rst || flash_clr) begin
            cr_rw <= '0;
        end else if (wr_ok) begin
            cr_rw[wr_idx] <= wr_value;
        end
    end

    // Write-first read: hardwired index, then jump clear, then same-cycle write.
    always_comb begin
        if (rd_idx == IW'(TRUE_IDX)) begin
            rd_bit = 1'b1;
        end else if (flash_clr) begin
            rd_bit = 1'b0;
        end else if (wr_valid && (wr_idx == rd_idx)) begin
            rd_bit = wr_value;
        end else begin
            rd_bit = cr_rw[rd_idx];
        end
    end

    AST_FLASH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(flash_clr) |-> (cr_rw == '0)); // R5

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_ok && !flash_clr) && !$past(rst)) |-> (cr_rw[$past(wr_idx)] == $past(wr_value))); // R2
endmodule

// File: rtl/slf_store_flags.sv
module slf_store_flags #(
    parameter int unsigned DEPTH = 48,
    parameter int unsigned IW    = $clog2(DEPTH),
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          push_safe,
    input  logic          pop,
    output logic          full,
    output logic          all_safe,
    output logic [CW-1:0] count
);
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] safe_q;
    logic [DEPTH-1:0] entry_ok;
    logic [IW-1:0]    head_q, tail_q;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld_q  <= '0;
            safe_q <= '0;
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
        end else begin
            if (do_pop) begin
                vld_q[head_q]  <= 1'b0;
                safe_q[head_q] <= 1'b0;
                head_q <= (head_q == IW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
            end
            if (do_push) begin
                vld_q[tail_q]  <= 1'b1;
                safe_q[tail_q] <= push_safe;
                tail_q <= (tail_q == IW'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // An entry blocks safety only when it holds an untagged store.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign entry_ok[g] = !vld_q[g] || safe_q[g];
    end
    assign all_safe = &entry_ok;

    AST_SQ_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(flush) |-> ((count == '0) && (vld_q == '0) && (safe_q == '0))); // R10

    AST_SQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (count <= CW'(DEPTH))); // R11

    AST_SQ_OCCUPANCY: assert property (@(posedge clk) disable iff (rst)
        ($countones(vld_q) == int'(count))); // R7
endmodule

// File: rtl/slf_load_alloc.sv
module slf_load_alloc #(
    parameter int unsigned DEPTH = 48,
    parameter int unsigned IW    = $clog2(DEPTH),
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          alloc,
    input  logic          release_i,
    output logic          full,
    output logic [IW-1:0] tail_idx,
    output logic [CW-1:0] count
);
    logic do_rel;

    assign full   = (count == CW'(DEPTH));
    assign do_rel = release_i && (count != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            tail_idx <= '0;
            count    <= '0;
        end else begin
            if (alloc) begin
                tail_idx <= (tail_idx == IW'(DEPTH - 1)) ? '0 : tail_idx + 1'b1;
            end
            count <= count + CW'(alloc) - CW'(do_rel);
        end
    end

    AST_LQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (count <= CW'(DEPTH))); // R8

    AST_LQ_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        full |-> !alloc); // R8
endmodule

// File: rtl/safe_load_filter.sv
module safe_load_filter
    import slf_pkg::*;
#(
    parameter int unsigned P_NUM_CR   = NUM_CR,
    parameter int unsigned P_TRUE_IDX = CR_TRUE_IDX,
    parameter int unsigned P_LQ_DEPTH = LQ_DEPTH,
    parameter int unsigned P_SQ_DEPTH = SQ_DEPTH,
    parameter int unsigned P_CR_W     = $clog2(P_NUM_CR),
    parameter int unsigned P_LQ_IW    = $clog2(P_LQ_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_valid,
    input  logic               ld_safe_op,
    input  logic [P_CR_W-1:0]  ld_cr_idx,
    input  logic               st_valid,
    input  logic               scope_mark,
    input  logic               cset_valid,
    input  logic [P_CR_W-1:0]  cset_idx,
    input  logic               cset_value,
    input  logic               ijump,
    input  logic               sq_retire,
    input  logic               lq_release,
    input  logic               flush,
    output logic               ld_stall,
    output logic               st_stall,
    output logic               cls_valid,
    output logic               cls_safe,
    output logic [P_LQ_IW-1:0] cls_lq_idx
);
    localparam int unsigned LQ_CW = $clog2(P_LQ_DEPTH + 1);
    localparam int unsigned SQ_CW = $clog2(P_SQ_DEPTH + 1);

    logic               cr_bit;
    logic               sq_full, sq_all_safe;
    logic [SQ_CW-1:0]   sq_count;
    logic               lq_full;
    logic [P_LQ_IW-1:0] lq_tail;
    logic [LQ_CW-1:0]   lq_count;
    logic               in_scope_q;
    logic               ld_is_safe, ld_go, lq_alloc, st_go;

    slf_cond_regs #(
        .NUM      (P_NUM_CR),
        .TRUE_IDX (P_TRUE_IDX),
        .IW       (P_CR_W)
    ) u_cregs (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (cset_valid),
        .wr_idx    (cset_idx),
        .wr_value  (cset_value),
        .flash_clr (ijump),
        .rd_idx    (ld_cr_idx),
        .rd_bit    (cr_bit)
    );

    assign ld_is_safe = sq_all_safe || (ld_safe_op && cr_bit);
    assign ld_stall   = ld_valid && !flush && !ld_is_safe && lq_full;
    assign ld_go      = ld_valid && !flush && !ld_stall;
    assign lq_alloc   = ld_go && !ld_is_safe;
    assign st_stall   = st_valid && !flush && sq_full;
    assign st_go      = st_valid && !flush && !sq_full;

    // Scope region opens on a marker and lasts until flush.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            in_scope_q <= 1'b0;
        end else if (scope_mark) begin
            in_scope_q <= 1'b1;
        end
    end

    slf_store_flags #(
        .DEPTH (P_SQ_DEPTH),
        .IW    ($clog2(P_SQ_DEPTH)),
        .CW    (SQ_CW)
    ) u_sflags (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (st_go),
        .push_safe (in_scope_q || scope_mark),
        .pop       (sq_retire),
        .full      (sq_full),
        .all_safe  (sq_all_safe),
        .count     (sq_count)
    );

    slf_load_alloc #(
        .DEPTH (P_LQ_DEPTH),
        .IW    (P_LQ_IW),
        .CW    (LQ_CW)
    ) u_lalloc (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .alloc     (lq_alloc),
        .release_i (lq_release),
        .full      (lq_full),
        .tail_idx  (lq_tail),
        .count     (lq_count)
    );

    load_cls_t cls_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= '0;
        end else begin
            cls_q.valid  <= ld_go;
            cls_q.safe   <= ld_is_safe;
            cls_q.lq_idx <= ld_is_safe ? '0 : LQ_IDX_W'(lq_tail);
        end
    end

    assign cls_valid  = cls_q.valid;
    assign cls_safe   = cls_q.safe;
    assign cls_lq_idx = P_LQ_IW'(cls_q.lq_idx);

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        cls_valid |-> ($past(ld_valid) && !$past(ld_stall) && !$past(flush))); // R9

    AST_SAFE_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
        (cls_valid && !$past(rst) && !$past(flush) && !$past(lq_release) && cls_safe)
            |-> (lq_count == $past(lq_count))); // R2

    AST_SQ_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_stall |-> (sq_count == SQ_CW'(P_SQ_DEPTH))); // R11
endmodule

// File: tb/safe_load_filter_tb.sv
module safe_load_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LQD = 48;
    localparam int SQD = 48;

    logic clk = 1'b0;
    logic rst;
    logic ld_valid, ld_safe_op, st_valid, scope_mark, cset_valid, cset_value;
    logic ijump, sq_retire, lq_release, flush;
    logic [2:0] ld_cr_idx, cset_idx;
    logic ld_stall, st_stall, cls_valid, cls_safe;
    logic [5:0] cls_lq_idx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    safe_load_filter u_dut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_safe_op(ld_safe_op),
        .ld_cr_idx(ld_cr_idx), .st_valid(st_valid), .scope_mark(scope_mark),
        .cset_valid(cset_valid), .cset_idx(cset_idx), .cset_value(cset_value),
        .ijump(ijump), .sq_retire(sq_retire), .lq_release(lq_release), .flush(flush),
        .ld_stall(ld_stall), .st_stall(st_stall), .cls_valid(cls_valid),
        .cls_safe(cls_safe), .cls_lq_idx(cls_lq_idx)
    );

    typedef struct { bit safe; int idx; string req; } exp_t;
    exp_t sb[$];

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // Reference model state
    bit [7:0] m_cr;
    bit m_sq[$];
    bit m_scope;
    int m_lq_cnt, m_lq_tail;

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        ld_valid = 0; ld_safe_op = 0; ld_cr_idx = 0; st_valid = 0; scope_mark = 0;
        cset_valid = 0; cset_idx = 0; cset_value = 0; ijump = 0;
        sq_retire = 0; lq_release = 0; flush = 0;
    endtask

    // Driver: inputs are already set at a falling edge; model, check stalls, advance.
    task automatic step();
        bit crb, alls, safe, exp_ls, exp_ss, exp_t_safe;
        exp_t e;
        if (ld_cr_idx == 3'd7) crb = 1;
        else if (ijump) crb = 0;
        else if (cset_valid && cset_idx == ld_cr_idx) crb = cset_value;
        else crb = m_cr[ld_cr_idx];
        alls = 1;
        foreach (m_sq[i]) if (!m_sq[i]) alls = 0;
        safe = (ld_safe_op && crb) || alls;
        exp_ls = ld_valid && !flush && !safe && (m_lq_cnt == LQD);
        exp_ss = st_valid && !flush && (m_sq.size() == SQD);
        #1;
        if (ld_valid) check(ld_stall == exp_ls, "R8", ld_stall, exp_ls, "ld_stall");
        if (st_valid) check(st_stall == exp_ss, "R11", st_stall, exp_ss, "st_stall");
        if (ld_valid && !exp_ls && !flush) begin
            e.safe = safe; e.idx = safe ? 0 : m_lq_tail; e.req = cur_req;
            sb.push_back(e);
        end
        exp_t_safe = m_scope || scope_mark;
        @(posedge clk);
        if (ijump) m_cr[6:0] = '0;
        else if (cset_valid && cset_idx != 3'd7) m_cr[cset_idx] = cset_value;
        if (flush) begin
            m_sq.delete(); m_scope = 0; m_lq_cnt = 0; m_lq_tail = 0;
        end else begin
            if (sq_retire && m_sq.size() > 0) void'(m_sq.pop_front());
            if (st_valid && !exp_ss) m_sq.push_back(exp_t_safe);
            if (scope_mark) m_scope = 1;
            if (lq_release && m_lq_cnt > 0) m_lq_cnt--;
            if (ld_valid && !exp_ls && !safe) begin
                m_lq_cnt++;
                m_lq_tail = (m_lq_tail + 1) % LQD;
            end
        end
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic load(input bit sop, input int idx);
        ld_valid = 1; ld_safe_op = sop; ld_cr_idx = 3'(idx); step();
    endtask
    task automatic store();
        st_valid = 1; step();
    endtask
    task automatic cset(input int idx, input bit v);
        cset_valid = 1; cset_idx = 3'(idx); cset_value = v; step();
    endtask

    // Monitor: compares each strobe with the oldest expected item.
    always @(negedge clk) begin
        if (!rst && cls_valid) begin
            if (sb.size() == 0) begin
                check(0, "R9", 1, 0, "unexpected strobe");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cls_safe == e.safe, e.req, cls_safe, e.safe, "cls_safe");
                check(int'(cls_lq_idx) == e.idx, "R9", cls_lq_idx, e.idx, "cls_lq_idx");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "R9", 0, 1, "watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_inputs();
        rst = 1;
        m_cr = 8'h80; m_scope = 0; m_lq_cnt = 0; m_lq_tail = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check(cls_valid == 0, "R1", cls_valid, 0, "cls_valid after reset");
        check(ld_stall == 0, "R1", ld_stall, 0, "ld_stall after reset");
        check(st_stall == 0, "R1", st_stall, 0, "st_stall after reset");

        cur_req = "R7"; load(0, 0);              // empty SQ: safe
        store();                                 // untagged store
        load(0, 0);                              // unsafe, slot 0
        cur_req = "R1"; load(1, 3);              // reg 3 cleared by reset: unsafe
        cur_req = "R2"; cset(3, 1); load(1, 3);  // now safe
        cset(3, 0); load(1, 3);                  // unsafe again
        cur_req = "R3"; load(1, 7);
        cset(7, 0); load(1, 7);                  // write ignored
        cur_req = "R4";
        cset_valid = 1; cset_idx = 5; cset_value = 1; ld_valid = 1; ld_safe_op = 1; ld_cr_idx = 5; step();
        cset_valid = 1; cset_idx = 5; cset_value = 0; ld_valid = 1; ld_safe_op = 1; ld_cr_idx = 5; step();
        cur_req = "R5";
        cset(2, 1); ijump = 1; step(); load(1, 2);
        cset(6, 1); ijump = 1; ld_valid = 1; ld_safe_op = 1; ld_cr_idx = 6; step();
        ijump = 1; cset_valid = 1; cset_idx = 4; cset_value = 1; step(); load(1, 4);
        load(1, 7);
        cur_req = "R10"; flush = 1; step(); load(0, 0);   // both queues emptied
        cur_req = "R6"; scope_mark = 1; st_valid = 1; step(); store(); load(0, 0);
        cur_req = "R10"; flush = 1; step(); store(); load(0, 1);  // scope ended, unsafe, slot 0
        cur_req = "R9";
        for (int i = 0; i < LQD - 1; i++) load(0, 0);     // fills slots 1..47
        cur_req = "R8"; load(0, 0);                       // stalled
        load(1, 7);                                       // safe passes
        lq_release = 1; ld_valid = 1; step();             // still full this cycle
        cur_req = "R9"; load(0, 0);                       // slot wraps to 0
        cur_req = "R7"; scope_mark = 1; step(); store(); load(0, 0);  // untagged head remains
        sq_retire = 1; step(); load(0, 0);                // only tagged stores left: safe
        cur_req = "R11"; flush = 1; step();
        for (int i = 0; i < SQD; i++) store();
        store();                                          // stalled
        cur_req = "R7";
        for (int i = 0; i < SQD; i++) begin sq_retire = 1; step(); end
        load(0, 0);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R9", sb.size(), 0, "strobes outstanding");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule